// File: doc/BRIEF.md
# Selectable-Action Watchdog Timer

This block is a software-liveness watchdog that counts one-second ticks. Firmware has to service it before the count reaches the timeout value, which is two seconds by default. If firmware does not, the block acts on the timeout in one of two ways, chosen by a configuration bit. It either drives a one-cycle system reset request, or it sets a sticky interrupt status bit that firmware clears by writing a one.

The block comes out of reset already armed and in reset-request mode. A hung system is therefore caught even before firmware configures anything. Any write to the service port restarts the count, and the data carried with that write is ignored.

The 1 Hz tick arrives on `tick_i` as a pulse one clock cycle wide. The reset tree and the interrupt routing sit outside this block.

Top module: `sel_wdt`

## Requirements
- R1: After reset, `en_o` is 1, `irq_mode_o` is 0 (reset-request mode), `count_o` is 0, `irq_sts_o` is 0 and `sys_rst_o` is 0.
- R2: While enabled, a cycle with `tick_i` high and no service write raises `count_o` by one at the next clock edge, unless the count is at its top value. Cycles without a tick leave the count unchanged.
- R3: A tick that arrives while `count_o` equals TIMEOUT-1 is a timeout. At that same edge `count_o` returns to 0, so the count never shows the value TIMEOUT (binary 10 by default).
- R4: In reset-request mode (`irq_mode_o` = 0), a timeout drives `sys_rst_o` high for exactly one clock cycle, starting at the edge that samples the timeout tick.
- R5: In interrupt mode (`irq_mode_o` = 1), a timeout sets `irq_sts_o` at the same edge and does not pulse `sys_rst_o`. The status bit stays set until it is cleared.
- R6: A write on the clear port with bit 0 of `irq_clr_data_i` set clears `irq_sts_o` at the next edge. A clear write with bit 0 at 0 leaves the status bit unchanged. A timeout in the same cycle as a clear wins, and the bit stays set.
- R7: A service write (`svc_we_i`) sets `count_o` to 0 at the next edge, whatever value `svc_data_i` carries.
- R8: A service write in the same cycle as a tick takes priority. The count becomes 0 and no timeout occurs, even when the count is at TIMEOUT-1.
- R9: While disabled, the count is forced to 0 and ticks are ignored. No timeout action occurs.
- R10: A configuration write (`cfg_we_i`) loads enable from bit 0 and the mode from bit 1 of `cfg_data_i` (1 = interrupt mode). The new values appear on `en_o` and `irq_mode_o` at the next edge. The counter acts on the new enable from the edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second tick, one clock wide |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_data_i | input | DATA_W | Configuration data: bit 0 enable, bit 1 mode |
| svc_we_i | input | 1 | Service write strobe |
| svc_data_i | input | DATA_W | Service write data (ignored) |
| irq_clr_we_i | input | 1 | Status clear write strobe |
| irq_clr_data_i | input | DATA_W | Clear data: bit 0 = 1 clears the status |
| en_o | output | 1 | Current enable |
| irq_mode_o | output | 1 | Current mode, 1 = interrupt |
| count_o | output | CNT_W | Current seconds count |
| irq_sts_o | output | 1 | Sticky timeout interrupt status |
| sys_rst_o | output | 1 | One-cycle system reset request |

## Verification
Every result is due one clock edge after the cycle that carries its stimulus:
- the count update;
- the reset pulse;
- the status set or clear;
- the new configuration.

The one exception is that the counter acts on a changed enable one edge later still. The bench drives inputs on the falling edge and, in the same task, pushes one expected item per cycle. A monitor pops that item one time unit after the next rising edge and compares it against all outputs. Each comparison therefore lands on exactly the edge where that result is first visible.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned CFG_EN_BIT   = 0;
  localparam int unsigned CFG_MODE_BIT = 1;
  localparam int unsigned CLR_BIT      = 0;

  typedef enum logic {
    ACT_RESET = 1'b0,
    ACT_IRQ   = 1'b1
  } wdt_act_e;
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              en_o,
  output wdt_act_e          act_o
);
  logic unused_cfg_bits;
  assign unused_cfg_bits = ^data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= 1'b1;
      act_o <= ACT_RESET;
    end else if (we_i) begin
      en_o  <= data_i[CFG_EN_BIT];
      act_o <= wdt_act_e'(data_i[CFG_MODE_BIT]);
    end
  end
endmodule

// File: rtl/wdt_sec_counter.sv
module wdt_sec_counter #(
  parameter int unsigned TIMEOUT = 2,
  localparam int unsigned CNT_W  = $clog2(TIMEOUT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             svc_i,
  output logic [CNT_W-1:0] count_o,
  output logic             timeout_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

  // service beats tick; a tick at LAST is the timeout
  assign timeout_o = en_i && !svc_i && tick_i && (count_o == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                count_o <= '0;
    else if (!en_i || svc_i)    count_o <= '0;
    else if (timeout_o)         count_o <= '0;
    else if (tick_i)            count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/wdt_action.sv
module wdt_action
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              timeout_i,
  input  wdt_act_e          act_i,
  input  logic              clr_we_i,
  input  logic [DATA_W-1:0] clr_data_i,
  output logic              sys_rst_o,
  output logic              irq_sts_o
);
  logic unused_clr_bits;
  assign unused_clr_bits = ^clr_data_i;

  logic set_irq, clr_irq;
  assign set_irq = timeout_i && (act_i == ACT_IRQ);
  assign clr_irq = clr_we_i && clr_data_i[CLR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sys_rst_o <= 1'b0;
      irq_sts_o <= 1'b0;
    end else begin
      sys_rst_o <= timeout_i && (act_i == ACT_RESET);
      if (set_irq)      irq_sts_o <= 1'b1;
      else if (clr_irq) irq_sts_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sel_wdt.sv
module sel_wdt
  import wdt_pkg::*;
#(
  parameter int unsigned TIMEOUT = 2,
  parameter int unsigned DATA_W  = 16,
  localparam int unsigned CNT_W  = $clog2(TIMEOUT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cfg_we_i,
  input  logic [DATA_W-1:0] cfg_data_i,
  input  logic              svc_we_i,
  input  logic [DATA_W-1:0] svc_data_i,
  input  logic              irq_clr_we_i,
  input  logic [DATA_W-1:0] irq_clr_data_i,
  output logic              en_o,
  output logic              irq_mode_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              irq_sts_o,
  output logic              sys_rst_o
);
  wdt_act_e act;
  logic     timeout;
  logic     unused_svc_data;

  assign unused_svc_data = ^svc_data_i;  // any value services
  assign irq_mode_o      = (act == ACT_IRQ);

  wdt_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .data_i (cfg_data_i),
    .en_o   (en_o),
    .act_o  (act)
  );

  wdt_sec_counter #(.TIMEOUT(TIMEOUT)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_o),
    .tick_i    (tick_i),
    .svc_i     (svc_we_i),
    .count_o   (count_o),
    .timeout_o (timeout)
  );

  wdt_action #(.DATA_W(DATA_W)) u_act (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .timeout_i  (timeout),
    .act_i      (act),
    .clr_we_i   (irq_clr_we_i),
    .clr_data_i (irq_clr_data_i),
    .sys_rst_o  (sys_rst_o),
    .irq_sts_o  (irq_sts_o)
  );
endmodule

// File: rtl/sel_wdt_chk.sv
module sel_wdt_chk #(
  parameter int unsigned TIMEOUT = 2,
  parameter int unsigned DATA_W  = 16,
  localparam int unsigned CNT_W  = $clog2(TIMEOUT + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              svc_we_i,
  input logic              irq_clr_we_i,
  input logic [DATA_W-1:0] irq_clr_data_i,
  input logic              en_o,
  input logic              irq_mode_o,
  input logic [CNT_W-1:0]  count_o,
  input logic              irq_sts_o,
  input logic              sys_rst_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

  a_r2_step_or_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o != $past(count_o)) |-> (count_o == '0 || count_o == CNT_W'($past(count_o) + 1'b1)));

  a_r3_wrap_at_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && tick_i && !svc_we_i && count_o == LAST) |=> (count_o == '0));

  a_r3_never_timeout_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= LAST);

  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |=> !sys_rst_o);

  a_r5_no_rst_in_irq_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> !$past(irq_mode_o));

  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_sts_o && !(irq_clr_we_i && irq_clr_data_i[0])) |=> irq_sts_o);

  a_r8_svc_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_we_i |=> (count_o == '0 && !sys_rst_o));

  a_r9_disabled_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_o |=> (count_o == '0 && !sys_rst_o));
endmodule

bind sel_wdt sel_wdt_chk #(.TIMEOUT(TIMEOUT), .DATA_W(DATA_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .tick_i         (tick_i),
  .svc_we_i       (svc_we_i),
  .irq_clr_we_i   (irq_clr_we_i),
  .irq_clr_data_i (irq_clr_data_i),
  .en_o           (en_o),
  .irq_mode_o     (irq_mode_o),
  .count_o        (count_o),
  .irq_sts_o      (irq_sts_o),
  .sys_rst_o      (sys_rst_o)
);

// File: tb/tb_sel_wdt.sv
module tb_sel_wdt;
  localparam int unsigned TIMEOUT = 2;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned CNT_W   = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b0, cfg_we = 1'b0, svc_we = 1'b0, clr_we = 1'b0;
  logic [DATA_W-1:0] cfg_data = '0, svc_data = '0, clr_data = '0;
  logic              en, mode, irq, srst;
  logic [CNT_W-1:0]  cnt;

  always #2 clk = ~clk;

  sel_wdt #(.TIMEOUT(TIMEOUT), .DATA_W(DATA_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .cfg_we_i(cfg_we), .cfg_data_i(cfg_data),
    .svc_we_i(svc_we), .svc_data_i(svc_data),
    .irq_clr_we_i(clr_we), .irq_clr_data_i(clr_data),
    .en_o(en), .irq_mode_o(mode), .count_o(cnt),
    .irq_sts_o(irq), .sys_rst_o(srst)
  );

  typedef struct {
    logic             en, mode, irq, rst;
    logic [CNT_W-1:0] cnt;
    string            tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  // reference state
  logic             m_en = 1'b1, m_mode = 1'b0, m_irq = 1'b0;
  logic [CNT_W-1:0] m_cnt = '0;

  task automatic step(input logic t, input logic sv, input logic [DATA_W-1:0] sd,
                      input logic cw, input logic [DATA_W-1:0] cd,
                      input logic kw, input logic [DATA_W-1:0] kd, input string tag);
    exp_t e;
    logic to;
    @(negedge clk);
    tick = t; svc_we = sv; svc_data = sd; cfg_we = cw; cfg_data = cd;
    clr_we = kw; clr_data = kd;
    to = m_en && !sv && t && (m_cnt == LAST);
    e.rst = to && !m_mode;
    if (to && m_mode)     m_irq = 1'b1;
    else if (kw && kd[0]) m_irq = 1'b0;
    if (!m_en || sv || to) m_cnt = '0;
    else if (t)            m_cnt = m_cnt + 1'b1;
    if (cw) begin m_en = cd[0]; m_mode = cd[1]; end
    e.en = m_en; e.mode = m_mode; e.irq = m_irq; e.cnt = m_cnt; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, '0, 0, '0, 0, '0, tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (en !== e.en || mode !== e.mode || cnt !== e.cnt || irq !== e.irq || srst !== e.rst) begin
        n_fail++;
        $display("FAIL %s: got en=%b mode=%b cnt=%0d irq=%b rst=%b exp en=%b mode=%b cnt=%0d irq=%b rst=%b",
                 e.tag, en, mode, cnt, irq, srst, e.en, e.mode, e.cnt, e.irq, e.rst);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    n_chk++;  // R1 reset state
    if (en !== 1'b1 || mode !== 1'b0 || cnt !== '0 || irq !== 1'b0 || srst !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: got en=%b mode=%b cnt=%0d irq=%b rst=%b exp 1 0 0 0 0", en, mode, cnt, irq, srst);
    end
    @(negedge clk); rst_n = 1'b1;
    idle(1, "R1");
    step(1, 0, '0, 0, '0, 0, '0, "R2");          // count 1
    idle(2, "R2");                                // holds
    step(1, 0, '0, 0, '0, 0, '0, "R3");          // timeout, reset pulse
    idle(1, "R4");                                // pulse ends
    step(1, 0, '0, 0, '0, 0, '0, "R2");
    step(0, 1, 16'hA5A5, 0, '0, 0, '0, "R7");    // service with data
    step(1, 0, '0, 0, '0, 0, '0, "R2");
    step(1, 1, 16'hFFFF, 0, '0, 0, '0, "R8");    // service beats tick at LAST
    idle(1, "R8");
    step(0, 0, '0, 1, 16'h0003, 0, '0, "R10");   // enable + irq mode
    step(1, 0, '0, 0, '0, 0, '0, "R2");
    step(1, 0, '0, 0, '0, 0, '0, "R5");          // timeout sets status
    idle(2, "R5");                                // sticky, no pulse
    step(0, 0, '0, 0, '0, 1, 16'hFFFE, "R6");    // bit0 clear: no effect
    step(0, 0, '0, 0, '0, 1, 16'h0001, "R6");    // cleared
    step(1, 0, '0, 0, '0, 0, '0, "R2");
    step(1, 0, '0, 0, '0, 1, 16'h0001, "R6");    // set wins over clear
    step(0, 0, '0, 0, '0, 1, 16'h0001, "R6");
    step(1, 0, '0, 0, '0, 0, '0, "R2");          // count 1
    step(0, 0, '0, 1, 16'h0000, 0, '0, "R10");   // disable, reset mode
    idle(1, "R9");                                // count forced 0
    step(1, 0, '0, 0, '0, 0, '0, "R9");
    step(1, 0, '0, 0, '0, 0, '0, "R9");
    step(1, 0, '0, 0, '0, 0, '0, "R9");
    step(0, 0, '0, 1, 16'h0001, 0, '0, "R10");   // re-enable, reset mode
    step(1, 0, '0, 0, '0, 0, '0, "R2");
    step(1, 0, '0, 0, '0, 0, '0, "R4");
    idle(2, "R4");
    wait (q.size() == 0);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hung run, exp completion");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule